// File: doc/BRIEF.md
# I2C Write-Only Target with Single-Byte Holding Buffer

This block is an I2C target that only receives. It samples SCL and SDA with the system clock and finds START and STOP conditions on the sampled lines. It shifts in an address byte and compares it with a fixed 7-bit device address. When the address matches and the request is a write, the block shifts in the data bytes that follow. Every byte that the block accepts goes into one holding register. This includes the address byte itself, so the host can see how the transfer was opened.

The block acknowledges a byte only when the holding register is empty and no overflow is pending. If a byte completes while the register still holds an unread value, the block raises a sticky overflow flag and does not acknowledge that byte. While the overflow flag stays set, the block refuses every later byte and leaves the register unchanged. The host side is a small set of pulse strobes with level outputs: one pulse reads the buffer, one clears the interrupt flag and one clears the overflow flag.

Top module: `i2c_rx_target`

## Requirements
- R1: After reset the buffer reads 0x00, all flags read 0 and SDA is not pulled low.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START in the middle of a byte restarts address reception. After a STOP, clocked bits are ignored until the next START.
- R3: The address byte is 7 address bits MSB first, then the R/W bit in bit 0. When the address matches and R/W is 0, the block pulls SDA low during the 9th SCL pulse if it is not blocked. It clears rw_flag, loads the whole address byte into the buffer and sets buf_full.
- R4: After an acknowledged write address, each data byte is received MSB first. An unblocked data byte is acknowledged in its 9th clock and loaded into the buffer.
- R5: irq_flag is set when any byte addressed to this target for writing completes, whether or not it is acknowledged. It stays set until a host_clr_irq pulse.
- R6: A host_rd pulse clears buf_full and leaves rx_buf unchanged.
- R7: A byte for this target that completes while buf_full is 1 sets ovf_flag. That byte is not acknowledged and the buffer keeps its old value.
- R8: ovf_flag is sticky and clears only on host_clr_ovf. While it is set, no byte is acknowledged or loaded, even after the buffer has been read.
- R9: When the address does not match, SDA is released and the rest of the transfer is ignored. The buffer and all flags stay unchanged.
- R10: A matching address with R/W equal to 1 sets rw_flag and is not acknowledged. The buffer, buf_full and irq_flag stay unchanged, and the rest of the transfer is ignored.
- R11: After any byte that is not acknowledged, later bytes in the same transfer are neither acknowledged nor loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line |
| sda_i | input | 1 | Sensed SDA line |
| sda_pull_low | output | 1 | When 1, the pad drives SDA low (acknowledge) |
| host_rd | input | 1 | Pulse: the host has read the buffer |
| host_clr_irq | input | 1 | Pulse: clear irq_flag |
| host_clr_ovf | input | 1 | Pulse: clear ovf_flag |
| rx_buf | output | 8 | Holding register for the last accepted byte |
| buf_full | output | 1 | The buffer holds an unread byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_flag | output | 1 | Per-byte interrupt flag |
| rw_flag | output | 1 | R/W bit of the last matching address byte |

## Verification
The assertions assume that SDA changes only while SCL is low, except when it forms a START or a STOP. They also assume that each SCL phase lasts longer than the synchronizer delay plus a few clocks, and that the host strobes are single-cycle pulses. The bench's bus tasks hold every SCL phase for several system clocks. They move SDA only at the midpoint of a low phase, except for the dedicated START and STOP tasks. Host strobes come from a task that raises the strobe for exactly one clock. The bench sees the acknowledge through a wired-AND of the controller's SDA and the block's pull-low output, sampled in the middle of the 9th SCL high phase.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_ACK,
      ST_IGNORE
   } rx_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;
   logic              scl_s;

   // idle bus is high, so reset everything to 1 to avoid false edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_s;
         sda_d    <= sda_s;
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s && !scl_d;
   assign scl_fall  = !scl_s && scl_d;
   assign start_det = scl_s && scl_d && sda_d && !sda_s;
   assign stop_det  = scl_s && scl_d && !sda_d && sda_s;

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
   import i2c_rx_pkg::*;
#(
   parameter int                ADDR_W   = 7,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h3A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              buf_full,
   input  logic              ovf_flag,
   output logic              sda_low,
   output logic              evt_load,
   output logic              evt_irq,
   output logic              evt_ovf,
   output logic              evt_rw,
   output logic              rw_bit,
   output logic [DATA_W-1:0] byte_val
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   rx_state_e         state;
   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              pend_ack;
   logic              rx_phase;
   logic              byte_done;
   logic              addr_hit;
   logic              for_us;

   always_comb begin
      rx_phase  = (state == ST_ADDR) || (state == ST_DATA);
      byte_val  = {shreg[DATA_W-2:0], sda_s};
      byte_done = rx_phase && scl_rise && (cnt == CNT_W'(DATA_W - 1))
                  && !start_det && !stop_det;
      addr_hit  = byte_val[DATA_W-1 -: ADDR_W] == DEV_ADDR;
      rw_bit    = byte_val[0];
      for_us    = byte_done && (((state == ST_ADDR) && addr_hit && !rw_bit)
                                || (state == ST_DATA));
      evt_load  = for_us && !buf_full && !ovf_flag;
      evt_ovf   = for_us && buf_full;
      evt_irq   = for_us;
      evt_rw    = byte_done && (state == ST_ADDR) && addr_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         cnt      <= '0;
         pend_ack <= 1'b0;
         sda_low  <= 1'b0;
      end else if (start_det) begin
         state    <= ST_ADDR;
         cnt      <= '0;
         pend_ack <= 1'b0;
         sda_low  <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         pend_ack <= 1'b0;
         sda_low  <= 1'b0;
      end else begin
         case (state)
            ST_ADDR, ST_DATA: begin
               if (scl_rise && (cnt != CNT_W'(DATA_W))) begin
                  shreg <= byte_val;
                  cnt   <= cnt + 1'b1;
               end
               if (byte_done) pend_ack <= evt_load;
               if (scl_fall && (cnt == CNT_W'(DATA_W))) begin
                  state   <= ST_ACK;
                  sda_low <= pend_ack;
                  cnt     <= '0;
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  sda_low <= 1'b0;
                  state   <= pend_ack ? ST_DATA : ST_IGNORE;
               end
            end
            default: ;
         endcase
      end
   end

   // R3 R4: the pull-down is only ever active inside the acknowledge slot
   a_r3_drive_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
      sda_low |-> (state == ST_ACK));

   // R2: a STOP releases the line and returns to idle
   a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det && !start_det |=> !sda_low && (state == ST_IDLE));

   // R11: after a refused byte nothing further is sampled as ours
   a_r11_no_rx_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> !evt_irq && !evt_load);

endmodule

// File: rtl/i2c_rx_status.sv
module i2c_rx_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_load,
   input  logic              evt_irq,
   input  logic              evt_ovf,
   input  logic              evt_rw,
   input  logic              rw_bit,
   input  logic [DATA_W-1:0] byte_val,
   input  logic              host_rd,
   input  logic              host_clr_irq,
   input  logic              host_clr_ovf,
   output logic [DATA_W-1:0] rx_buf,
   output logic              buf_full,
   output logic              ovf_flag,
   output logic              irq_flag,
   output logic              rw_flag
);

   // a set event always wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf   <= '0;
         buf_full <= 1'b0;
         ovf_flag <= 1'b0;
         irq_flag <= 1'b0;
         rw_flag  <= 1'b0;
      end else begin
         if (evt_load)          rx_buf   <= byte_val;
         if (evt_load)          buf_full <= 1'b1;
         else if (host_rd)      buf_full <= 1'b0;
         if (evt_ovf)           ovf_flag <= 1'b1;
         else if (host_clr_ovf) ovf_flag <= 1'b0;
         if (evt_irq)           irq_flag <= 1'b1;
         else if (host_clr_irq) irq_flag <= 1'b0;
         if (evt_rw)            rw_flag  <= rw_bit;
      end
   end

   a_r7_no_load_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      evt_load |-> !buf_full && !ovf_flag);

   a_r6_full_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      evt_load |=> buf_full && (rx_buf == $past(byte_val)));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !host_clr_ovf |=> ovf_flag);

   a_r8_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> $stable(rx_buf));

   a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag && !host_clr_irq |=> irq_flag);

endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target #(
   parameter int                ADDR_W      = 7,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h3A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_low,
   input  logic              host_rd,
   input  logic              host_clr_irq,
   input  logic              host_clr_ovf,
   output logic [DATA_W-1:0] rx_buf,
   output logic              buf_full,
   output logic              ovf_flag,
   output logic              irq_flag,
   output logic              rw_flag
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_rx_target: SYNC_STAGES must be at least 2");
   end
   if (DATA_W != ADDR_W + 1) begin : g_bad_width
      $error("i2c_rx_target: DATA_W must equal ADDR_W + 1");
   end

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              evt_load;
   logic              evt_irq;
   logic              evt_ovf;
   logic              evt_rw;
   logic              rw_bit;
   logic [DATA_W-1:0] byte_val;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_rx_ctrl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .DEV_ADDR (DEV_ADDR)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_s     (sda_s),
      .start_det (start_det),
      .stop_det  (stop_det),
      .buf_full  (buf_full),
      .ovf_flag  (ovf_flag),
      .sda_low   (sda_pull_low),
      .evt_load  (evt_load),
      .evt_irq   (evt_irq),
      .evt_ovf   (evt_ovf),
      .evt_rw    (evt_rw),
      .rw_bit    (rw_bit),
      .byte_val  (byte_val)
   );

   i2c_rx_status #(.DATA_W(DATA_W)) u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_load     (evt_load),
      .evt_irq      (evt_irq),
      .evt_ovf      (evt_ovf),
      .evt_rw       (evt_rw),
      .rw_bit       (rw_bit),
      .byte_val     (byte_val),
      .host_rd      (host_rd),
      .host_clr_irq (host_clr_irq),
      .host_clr_ovf (host_clr_ovf),
      .rx_buf       (rx_buf),
      .buf_full     (buf_full),
      .ovf_flag     (ovf_flag),
      .irq_flag     (irq_flag),
      .rw_flag      (rw_flag)
   );

endmodule

// File: tb/sim_i2c_rx_target.sv
module sim_i2c_rx_target;

   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 6;

   typedef struct packed {
      logic [7:0] adr;
      logic [7:0] dat;
      logic       rd_mid;
      logic       ack_a;
      logic       ack_d;
      logic [7:0] buf_e;
      logic       full_e;
      logic       ovf_e;
      logic       irq_e;
      logic       rw_e;
   } vec_t;

   // device address 0x3A: write byte 0x74, read byte 0x75
   localparam vec_t VEC [7] = '{
      '{8'h74, 8'h5C, 1'b1, 1'b1, 1'b1, 8'h5C, 1'b1, 1'b0, 1'b1, 1'b0},
      '{8'h74, 8'hA3, 1'b0, 1'b1, 1'b0, 8'h74, 1'b1, 1'b1, 1'b1, 1'b0},
      '{8'h22, 8'h99, 1'b0, 1'b0, 1'b0, 8'h74, 1'b0, 1'b0, 1'b0, 1'b0},
      '{8'h75, 8'h66, 1'b0, 1'b0, 1'b0, 8'h74, 1'b0, 1'b0, 1'b0, 1'b1},
      '{8'h74, 8'h01, 1'b1, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0},
      '{8'h74, 8'hFF, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0},
      '{8'h74, 8'h80, 1'b0, 1'b1, 1'b0, 8'h74, 1'b1, 1'b1, 1'b1, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       host_rd = 1'b0;
   logic       host_clr_irq = 1'b0;
   logic       host_clr_ovf = 1'b0;
   logic       sda_pull_low;
   logic [7:0] rx_buf;
   logic       buf_full;
   logic       ovf_flag;
   logic       irq_flag;
   logic       rw_flag;
   logic       sda_line;
   int         total = 0;
   int         bad = 0;

   assign sda_line = sda_m & ~sda_pull_low;

   always #(CLK_PERIOD / 2) clk = ~clk;

   i2c_rx_target u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .sda_pull_low (sda_pull_low),
      .host_rd      (host_rd),
      .host_clr_irq (host_clr_irq),
      .host_clr_ovf (host_clr_ovf),
      .rx_buf       (rx_buf),
      .buf_full     (buf_full),
      .ovf_flag     (ovf_flag),
      .irq_flag     (irq_flag),
      .rw_flag      (rw_flag)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wt(QTR);
      scl_m = 1'b1; wt(QTR);
      sda_m = 1'b0; wt(QTR);
      scl_m = 1'b0; wt(QTR);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(QTR);
      scl_m = 1'b1; wt(QTR);
      sda_m = 1'b1; wt(QTR);
   endtask

   task automatic bit_tx(input logic b);
      sda_m = b;    wt(QTR);
      scl_m = 1'b1; wt(2 * QTR);
      scl_m = 1'b0; wt(QTR);
   endtask

   task automatic byte_tx(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) bit_tx(b[i]);
      sda_m = 1'b1; wt(QTR);
      scl_m = 1'b1; wt(QTR);
      ack = ~sda_line;
      wt(QTR);
      scl_m = 1'b0; wt(QTR);
   endtask

   task automatic pulse(input logic rd, input logic ci, input logic co);
      host_rd = rd; host_clr_irq = ci; host_clr_ovf = co;
      wt(1);
      host_rd = 1'b0; host_clr_irq = 1'b0; host_clr_ovf = 1'b0;
      wt(1);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic a;
      logic d;
      wt(4);
      // R1 reset state
      chk("R1 rx_buf", rx_buf, 8'h00);
      chk("R1 flags", {4'h0, buf_full, ovf_flag, irq_flag, rw_flag}, 8'h00);
      chk("R1 sda released", {7'h0, sda_pull_low}, 8'h00);
      rst_n = 1'b1;
      wt(4);

      // table-driven write transactions: R3 R4 R5 R7 R9 R10 R11
      for (int v = 0; v < 7; v++) begin
         pulse(1'b1, 1'b1, 1'b1);
         bus_start();
         byte_tx(VEC[v].adr, a);
         chk($sformatf("R3 R9 R10 address ack v%0d", v), {7'h0, a}, {7'h0, VEC[v].ack_a});
         if (VEC[v].rd_mid) begin
            chk($sformatf("R3 address byte in buffer v%0d", v), rx_buf, VEC[v].adr);
            pulse(1'b1, 1'b0, 1'b0);
         end
         byte_tx(VEC[v].dat, d);
         chk($sformatf("R4 R7 R11 data ack v%0d", v), {7'h0, d}, {7'h0, VEC[v].ack_d});
         bus_stop();
         wt(8);
         chk($sformatf("R4 R7 R9 buffer v%0d", v), rx_buf, VEC[v].buf_e);
         chk($sformatf("R3 R7 full v%0d", v), {7'h0, buf_full}, {7'h0, VEC[v].full_e});
         chk($sformatf("R7 ovf v%0d", v), {7'h0, ovf_flag}, {7'h0, VEC[v].ovf_e});
         chk($sformatf("R5 R9 irq v%0d", v), {7'h0, irq_flag}, {7'h0, VEC[v].irq_e});
         chk($sformatf("R3 R10 rw v%0d", v), {7'h0, rw_flag}, {7'h0, VEC[v].rw_e});
      end

      // R5: irq holds, then clears on strobe
      wt(20);
      chk("R5 irq held", {7'h0, irq_flag}, 8'h01);
      pulse(1'b0, 1'b1, 1'b0);
      chk("R5 irq cleared", {7'h0, irq_flag}, 8'h00);

      // R6 R8: reading clears full only; overflow still blocks
      pulse(1'b1, 1'b0, 1'b0);
      chk("R6 full cleared", {7'h0, buf_full}, 8'h00);
      chk("R6 buffer kept", rx_buf, 8'h74);
      chk("R8 ovf survives read", {7'h0, ovf_flag}, 8'h01);
      bus_start();
      byte_tx(8'h74, a);
      chk("R8 address refused while ovf", {7'h0, a}, 8'h00);
      byte_tx(8'h42, d);
      chk("R8 R11 data refused while ovf", {7'h0, d}, 8'h00);
      bus_stop();
      wt(8);
      chk("R8 buffer frozen", rx_buf, 8'h74);
      chk("R8 full stays clear", {7'h0, buf_full}, 8'h00);
      chk("R5 irq on refused byte", {7'h0, irq_flag}, 8'h01);
      pulse(1'b0, 1'b1, 1'b1);
      chk("R8 ovf cleared by strobe", {7'h0, ovf_flag}, 8'h00);
      bus_start();
      byte_tx(8'h74, a);
      chk("R8 address accepted after clear", {7'h0, a}, 8'h01);
      pulse(1'b1, 1'b0, 1'b0);
      byte_tx(8'h3C, d);
      chk("R4 data accepted after clear", {7'h0, d}, 8'h01);
      bus_stop();
      wt(8);
      chk("R4 buffer after clear", rx_buf, 8'h3C);
      pulse(1'b1, 1'b1, 1'b0);

      // R2: repeated START in the middle of a byte restarts the address
      bus_start();
      bit_tx(1'b1); bit_tx(1'b0); bit_tx(1'b1); bit_tx(1'b1);
      bus_start();
      byte_tx(8'h74, a);
      chk("R2 restart address ack", {7'h0, a}, 8'h01);
      bus_stop();
      wt(8);
      chk("R2 restart address loaded", rx_buf, 8'h74);
      chk("R2 restart full", {7'h0, buf_full}, 8'h01);
      pulse(1'b1, 1'b1, 1'b0);

      // R2: bits after STOP without START are ignored
      scl_m = 1'b0; wt(QTR);
      byte_tx(8'h74, a);
      chk("R2 no ack without START", {7'h0, a}, 8'h00);
      bus_stop();
      wt(8);
      chk("R2 full untouched without START", {7'h0, buf_full}, 8'h00);
      chk("R2 irq untouched without START", {7'h0, irq_flag}, 8'h00);

      finish_run();
   end

endmodule